// File: doc/BRIEF.md
# Fractional Scaler with Unity Bypass

This block scales an unsigned fraction by an unsigned factor that lies between zero and exactly one. The operand `a_in` is read as the binary fraction 0.a7…a0. The factor `f_in` is one bit wider than `a_in`. Its top bit is an integer bit, and it may be set only for the code that means exactly 1.0. The result `y_out` is a fraction of the same width as `a_in`. For a factor below one, the result is the upper half of the unsigned product of `a_in` and the fraction bits of `f_in`; the lower half is dropped, so the result is rounded down. For a factor of exactly one, a 2-input select steered by the integer bit passes `a_in` through unchanged. This is needed because the fraction bits are then all zero and the product would be zero.

A factor code with the integer bit set and any fraction bit set is not allowed. The block raises `bad_f` for such a code, and the output still takes the pass-through path. A build parameter picks the timing. In the combinational variant, the result appears in the same cycle. In the registered variant, both the inputs and the outputs are registered, giving two cycles of latency, and a valid flag travels alongside the data.

Top module: `frac_scaler`

## Requirements
- R1: When f_in[8] is 0, y_out equals bits [15:8] of the 16-bit unsigned product a_in × f_in[7:0]. This is floor(a_in × f_in / 256).
- R2: When f_in[8] is 1, y_out equals a_in, and the multiplier result is ignored.
- R3: bad_f is 1 exactly when f_in[8] is 1 and f_in[7:0] is not zero. In that case y_out still equals a_in.
- R4: With PIPE_MODE = 1, y_out, bad_f and out_valid reflect the inputs that were presented two rising edges earlier. out_valid repeats in_valid with that delay.
- R5: With PIPE_MODE = 0, y_out, bad_f and out_valid follow the inputs in the same cycle, and out_valid equals in_valid.
- R6: With PIPE_MODE = 1, a rising edge with rst high (synchronous, active high) clears y_out, bad_f and out_valid to 0.
- R7: For any factor with f_in[8] = 0, y_out is never greater than the a_in it was computed from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a_in and f_in as carrying a sample |
| a_in | input | A_W (8) | Unsigned fraction 0.a7…a0 |
| f_in | input | A_W+1 (9) | Scale factor; bit 8 is the integer bit, 0x100 = 1.0 |
| out_valid | output | 1 | in_valid, delayed to line up with y_out |
| y_out | output | A_W (8) | Scaled fraction |
| bad_f | output | 1 | Disallowed factor code seen |

## Verification
Two outcomes can arise from the same factor code in one cycle: the pass-through select and the bad-code flag. Both fire when the integer bit is set and fraction bits are also set. The bench drives a spread of such codes with varied operands. It expects `y_out` to equal `a_in` and `bad_f` to be high in the same output cycle. It also checks the legal 1.0 code, which must select the pass-through with the flag low. These checks are judged against a behavioural model, and a queue delays the expected values by the pipeline depth for the registered instance. A combinational instance runs next to it on the same stimulus. Valid gaps and a reset in mid-stream are mixed into a full sweep of operand and factor, so that data, valid and reset behaviour are all compared in the same cycles.

// File: rtl/frac_scaler_pkg.sv
package frac_scaler_pkg;

   // Timing variants of the scaler
   typedef enum int {
      PIPE_COMB = 0,
      PIPE_REG2 = 1
   } pipe_mode_e;

   // Widest fraction the multiplier is meant to be built for
   localparam int MAX_FRAC_W = 32;
   localparam int MIN_FRAC_W = 2;

endpackage

// File: rtl/fs_stage.sv
module fs_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/fs_mul_hi.sv
module fs_mul_hi #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] m,
   output logic [W-1:0] hi
);

   localparam int PW = 2 * W;

   logic [PW-1:0] pp [W];
   logic [PW-1:0] acc;

   // one shifted partial product per multiplier bit
   genvar i;
   generate
      for (i = 0; i < W; i++) begin : g_row
         assign pp[i] = m[i] ? (PW'(x) << i) : '0;
      end
   endgenerate

   always_comb begin
      acc = '0;
      for (int k = 0; k < W; k++) acc = acc + pp[k];
   end

   // keep the upper half only: floor(x*m / 2^W)
   assign hi = W'(acc >> W);

endmodule

// File: rtl/fs_unity_sel.sv
module fs_unity_sel #(
   parameter int W = 8
) (
   input  logic         unity,
   input  logic [W-1:0] frac_bits,
   input  logic [W-1:0] a,
   input  logic [W-1:0] prod,
   output logic [W-1:0] y,
   output logic         bad
);

   logic [W-1:0] cand [2];

   assign cand[0] = prod;
   assign cand[1] = a;
   assign y       = cand[unity];
   assign bad     = unity & (|frac_bits);

endmodule

// File: rtl/frac_scaler.sv
module frac_scaler
   import frac_scaler_pkg::*;
#(
   parameter int A_W       = 8,
   parameter int PIPE_MODE = PIPE_REG2
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           in_valid,
   input  logic [A_W-1:0] a_in,
   input  logic [A_W:0]   f_in,
   output logic           out_valid,
   output logic [A_W-1:0] y_out,
   output logic           bad_f
);

   localparam int F_W   = A_W + 1;
   localparam int IN_W  = 1 + F_W + A_W;
   localparam int OUT_W = 1 + A_W + 1;

   generate
      if (PIPE_MODE != PIPE_COMB && PIPE_MODE != PIPE_REG2) begin : g_bad_mode
         $error("frac_scaler: PIPE_MODE must be 0 or 1");
      end
      if (A_W < MIN_FRAC_W || A_W > MAX_FRAC_W) begin : g_bad_width
         $error("frac_scaler: A_W out of supported range");
      end
   endgenerate

   logic           s_v;
   logic [A_W-1:0] s_a;
   logic [F_W-1:0] s_f;
   logic [A_W-1:0] prod_hi;
   logic [A_W-1:0] sel_y;
   logic           sel_bad;

   generate
      if (PIPE_MODE == PIPE_REG2) begin : g_in_reg
         fs_stage #(.W(IN_W)) u_in (
            .clk (clk),
            .rst (rst),
            .d   ({in_valid, f_in, a_in}),
            .q   ({s_v, s_f, s_a})
         );
      end else begin : g_in_comb
         assign s_v = in_valid;
         assign s_f = f_in;
         assign s_a = a_in;
      end
   endgenerate

   fs_mul_hi #(.W(A_W)) u_mul (
      .x  (s_a),
      .m  (s_f[A_W-1:0]),
      .hi (prod_hi)
   );

   fs_unity_sel #(.W(A_W)) u_sel (
      .unity     (s_f[A_W]),
      .frac_bits (s_f[A_W-1:0]),
      .a         (s_a),
      .prod      (prod_hi),
      .y         (sel_y),
      .bad       (sel_bad)
   );

   generate
      if (PIPE_MODE == PIPE_REG2) begin : g_out_reg
         fs_stage #(.W(OUT_W)) u_out (
            .clk (clk),
            .rst (rst),
            .d   ({s_v, sel_y, sel_bad}),
            .q   ({out_valid, y_out, bad_f})
         );
      end else begin : g_out_comb
         assign out_valid = s_v;
         assign y_out     = sel_y;
         assign bad_f     = sel_bad;
      end
   endgenerate

endmodule

// File: rtl/fs_chk.sv
module fs_chk #(
   parameter int A_W       = 8,
   parameter int PIPE_MODE = 1
) (
   input logic           clk,
   input logic           rst,
   input logic           in_valid,
   input logic [A_W-1:0] a_in,
   input logic [A_W:0]   f_in,
   input logic           out_valid,
   input logic [A_W-1:0] y_out,
   input logic           bad_f
);

   generate
      if (PIPE_MODE == 1) begin : g_reg_chk
         logic [1:0] warm;
         always_ff @(posedge clk) begin
            if (rst)              warm <= 2'd0;
            else if (warm != 2'd2) warm <= warm + 2'd1;
         end

         // R4
         valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd2) |-> (out_valid == $past(in_valid, 2)));

         // R2
         unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd2 && $past(f_in[A_W], 2)) |-> (y_out == $past(a_in, 2)));

         // R3
         bad_code_chk: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd2) |->
            (bad_f == ($past(f_in[A_W], 2) && ($past(f_in[A_W-1:0], 2) != '0))));

         // R7
         no_growth_chk: assert property (@(posedge clk) disable iff (rst)
            (warm == 2'd2 && !$past(f_in[A_W], 2)) |-> (y_out <= $past(a_in, 2)));

         // R6
         reset_clear_chk: assert property (@(posedge clk)
            rst |=> (!out_valid && y_out == '0 && !bad_f));
      end else begin : g_comb_chk
         // R5
         comb_valid_chk: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);

         // R2
         comb_unity_chk: assert property (@(posedge clk) disable iff (rst)
            f_in[A_W] |-> (y_out == a_in));

         // R3
         comb_bad_chk: assert property (@(posedge clk) disable iff (rst)
            bad_f == (f_in[A_W] && (f_in[A_W-1:0] != '0)));

         // R7
         comb_growth_chk: assert property (@(posedge clk) disable iff (rst)
            !f_in[A_W] |-> (y_out <= a_in));
      end
   endgenerate

endmodule

bind frac_scaler fs_chk #(.A_W(A_W), .PIPE_MODE(PIPE_MODE)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .a_in      (a_in),
   .f_in      (f_in),
   .out_valid (out_valid),
   .y_out     (y_out),
   .bad_f     (bad_f)
);

// File: tb/sim_frac_scaler.sv
module sim_frac_scaler;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       iv  = 1'b0;
   logic [7:0] a   = 8'd0;
   logic [8:0] f   = 9'd0;

   logic       o_v, o_e, c_v, c_e;
   logic [7:0] o_y, c_y;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct packed {
      logic       v;
      logic [7:0] y;
      logic       e;
   } exp_t;

   exp_t q[$];

   always #4 clk = ~clk;   // 125 MHz

   frac_scaler #(.A_W(8), .PIPE_MODE(1)) u0 (
      .clk(clk), .rst(rst), .in_valid(iv), .a_in(a), .f_in(f),
      .out_valid(o_v), .y_out(o_y), .bad_f(o_e));

   frac_scaler #(.A_W(8), .PIPE_MODE(0)) u1 (
      .clk(clk), .rst(rst), .in_valid(iv), .a_in(a), .f_in(f),
      .out_valid(c_v), .y_out(c_y), .bad_f(c_e));

   function automatic exp_t model(logic v, logic [7:0] av, logic [8:0] fv);
      exp_t r;
      int   p;
      p   = int'(av) * int'(fv[7:0]);
      r.v = v;
      r.y = fv[8] ? av : 8'(p >> 8);
      r.e = fv[8] && (fv[7:0] != 8'd0);
      return r;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(logic v, logic [7:0] av, logic [8:0] fv);
      exp_t e;
      exp_t m;
      @(negedge clk);
      e = q.pop_front();
      chk(o_y == e.y, "R1/R2 y_out registered", o_y, e.y);
      chk(o_v == e.v, "R4 out_valid delay", o_v, e.v);
      chk(o_e == e.e, "R3 bad_f registered", o_e, e.e);
      iv = v; a = av; f = fv;
      q.push_back(model(v, av, fv));
      #1;
      m = model(v, av, fv);
      if (fv[8]) chk(c_y == m.y, "R2 y_out comb bypass", c_y, m.y);
      else       chk(c_y == m.y, "R1 y_out comb product", c_y, m.y);
      chk(c_v == v, "R5 out_valid comb", c_v, v);
      chk(c_e == m.e, "R3 bad_f comb", c_e, m.e);
      if (!fv[8]) chk(c_y <= av, "R7 y_out not above a_in", c_y, av);
   endtask

   task automatic reset_seq();
      @(negedge clk);
      rst = 1'b1; iv = 1'b0; a = 8'd0; f = 9'd0;
      q.delete();
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // R6: outputs cleared by the edges with rst high
      chk(o_v == 1'b0, "R6 out_valid after reset", o_v, 0);
      chk(o_y == 8'd0, "R6 y_out after reset", o_y, 0);
      chk(o_e == 1'b0, "R6 bad_f after reset", o_e, 0);
      q.push_back('0);
      q.push_back('0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      reset_seq();

      // corners: 1.0 bypass at both extremes, largest product
      step(1'b1, 8'hFF, 9'h100);   // R2 -> 255
      step(1'b1, 8'h00, 9'h100);   // R2 -> 0
      step(1'b1, 8'hFF, 9'h0FF);   // R1 -> 0xFE
      step(1'b0, 8'h80, 9'h080);   // R1 -> 0x40, valid low
      step(1'b1, 8'h01, 9'h0FF);   // R1 -> 0

      // full sweep of legal codes with valid gaps
      for (int ai = 0; ai < 256; ai++) begin
         for (int fi = 0; fi < 257; fi++) begin
            step(((ai * 3 + fi) % 5) != 0, 8'(ai), 9'(fi));
         end
      end

      // disallowed codes: bypass and flag together (R3)
      for (int k = 1; k < 256; k += 17) begin
         step(1'b1, 8'(k * 7 + 3), 9'(256 + k));
         step(k[0], 8'(k), 9'h100);
      end

      // reset in mid-stream (R6)
      step(1'b1, 8'hAA, 9'h1FF);
      step(1'b1, 8'h55, 9'h0C0);
      reset_seq();
      step(1'b1, 8'hC3, 9'h0A5);
      step(1'b1, 8'h3C, 9'h181);
      step(1'b0, 8'h00, 9'h000);
      step(1'b0, 8'h00, 9'h000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule